// File: doc/BRIEF.md
# Bus-Master Service Cycle Sequencer

This block is the master side of a shared peripheral bus. It answers the device-controller side of each service cycle. When a controller pulls the wired service-call line, the sequencer raises the function strobe together with the service-acknowledge indicator. It then waits for the strobe acknowledge and latches the address that the winning controller drives on the response lines. After that it paces each data transfer with a closed-loop request-strobe handshake. The acknowledge is held back by a programmable number of cycles when the strobe rises, and it is dropped in the same cycle the strobe falls. The acknowledge that closes the connection carries end-service.

The sequencer also starts interrupt-acknowledge cycles. It does so only when the CPU asks for one while an interrupt call is pending. Such a cycle only fetches the controller address and has no transfers. If no controller acknowledges a strobe within a fixed window, the sequencer abandons the cycle and pulses an error flag. A per-connection byte counter follows the configured path width of one, two or four bytes.

Top module: `svc_seq_top`

## Requirements
- R1: In idle with `svcCallIn` high, the cycle after the sampling edge has `fsOut` and `ascOut` high. `ascOut` is never raised by `aioReqIn`.
- R2: At most one of `ascOut`/`aioOut` is high at any time, and neither is high without `fsOut`.
- R3: On the edge where `fslIn` is sampled high while `fsOut` is high, `devAddrOut` loads `frIn`, and `fsOut` and the indicator are low from the next cycle on. The request-strobe phase (or the return to idle) starts only after `fslIn` is sampled low.
- R4: In idle with `svcCallIn` low, `aioReqIn` together with `intCallIn` raises `fsOut` and `aioOut` in the next cycle. `aioReqIn` without `intCallIn` has no effect. `svcCallIn` wins when both requests are present. An interrupt-acknowledge cycle returns to idle after `fslIn` falls and runs no transfers.
- R5: Let E be the first edge that samples `rsIn` high while waiting for a transfer. `rsaOut` goes high after edge E+`cfgRsaDelay`+1 (counted in edges), provided `rsIn` is still high.
- R6: `rsaOut` is low in any cycle where `rsIn` is low. It is dropped combinationally, in the same cycle.
- R7: `esOut` is high only with `rsaOut`. It is high on the transfer whose count reaches a nonzero `cfgXferLimit`. Once `rsIn` falls after that acknowledge, the sequencer returns to idle.
- R8: `edIn` sampled high on any edge of the connection before the acknowledge phase makes the next acknowledge final, with `esOut`. `cfgXferLimit` = 0 means no count limit.
- R9: `byteCountOut` is cleared when a cycle starts. It grows by 1, 2 or 4 on each acknowledged transfer, for `cfgWidth` codes 0, 1 and 2 (code 3 counts as 4).
- R10: If `fslIn` has not been sampled high after TIMEOUT_CYC strobe cycles, `fsOut` and the indicator drop. `noRespErrOut` then pulses high for one cycle and the sequencer goes idle.
- R11: During and just after reset, all strobe, indicator, acknowledge and error outputs are low, and `devAddrOut` and `byteCountOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| svcCallIn | input | 1 | Wired service call from controllers |
| intCallIn | input | 1 | Wired interrupt call from controllers |
| aioReqIn | input | 1 | CPU request for an interrupt-acknowledge cycle |
| fslIn | input | 1 | Function strobe acknowledge |
| frIn | input | 8 | Function response lines (controller address) |
| rsIn | input | 1 | Request strobe from the connected controller |
| edIn | input | 1 | End-data from the controller |
| cfgRsaDelay | input | 4 | Extra acknowledge delay in cycles |
| cfgXferLimit | input | 8 | Transfers per connection, 0 = unlimited |
| cfgWidth | input | 2 | Path width code: 0=1, 1=2, 2/3=4 bytes |
| fsOut | output | 1 | Function strobe |
| ascOut | output | 1 | Service-acknowledge indicator |
| aioOut | output | 1 | Interrupt-acknowledge indicator |
| rsaOut | output | 1 | Request strobe acknowledge |
| esOut | output | 1 | End service |
| devAddrOut | output | 8 | Latched controller address |
| byteCountOut | output | 16 | Bytes moved in the current connection |
| noRespErrOut | output | 1 | One-cycle no-response error pulse |

## Verification
The bench runs several service connections with different settings. These include acknowledge delays of 0 and 2, widths of one, two and four bytes, and a limit that ends the connection. One case ends the connection with end-data instead, which shows that the two end conditions are independent. Interrupt requests are tried three ways: without a pending call, with one, and racing a service call. These cases separate the gating of the interrupt cycle from its priority. A strobe that is never acknowledged exercises the timeout path. Because the strobe is dropped a few cycles after each acknowledge, the bench can tell a release that is combinational from one that is registered.

// File: rtl/svc_seq_pkg.sv
package svc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_WDROP,
    ST_RSWAIT,
    ST_RSDLY,
    ST_RSACK
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCyc;
    logic latchAddr;
    logic tmrInc;
    logic loadDly;
    logic decDly;
    logic countXfer;
    logic sampleEd;
  } dpCtl_t;

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (code)
      2'd0:    widthBytes = 3'd1;
      2'd1:    widthBytes = 3'd2;
      default: widthBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/svc_seq_dp.sv
module svc_seq_dp
  import svc_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DLY_W       = 4,
  parameter int XFER_W      = 8,
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] frIn,
  input  logic              edIn,
  input  logic [DLY_W-1:0]  cfgRsaDelay,
  input  logic [XFER_W-1:0] cfgXferLimit,
  input  logic [1:0]        cfgWidth,
  output logic              timerDone,
  output logic              dlyZero,
  output logic              finalXfer,
  output logic [ADDR_W-1:0] devAddr,
  output logic [CNT_W-1:0]  byteCount
);

  localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [XFER_W-1:0] XFER_MAX = {XFER_W{1'b1}};

  logic [TMR_W-1:0]  tmr;
  logic [DLY_W-1:0]  dlyCnt;
  logic [XFER_W-1:0] xferCnt;
  logic              edSeen;
  logic [CNT_W-1:0]  byteStep;

  assign byteStep = CNT_W'(widthBytes(cfgWidth));

  // strobe timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (ctl.startCyc)  tmr <= '0;
    else if (ctl.tmrInc)    tmr <= tmr + 1'b1;
  end
  assign timerDone = (tmr == TMR_LAST);

  // acknowledge delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dlyCnt <= '0;
    else if (ctl.loadDly)  dlyCnt <= cfgRsaDelay;
    else if (ctl.decDly)   dlyCnt <= dlyCnt - 1'b1;
  end
  assign dlyZero = (dlyCnt == '0);

  // transfer counter, saturating so an unlimited connection never wraps to final
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  xferCnt <= '0;
    else if (ctl.startCyc)                      xferCnt <= '0;
    else if (ctl.countXfer && xferCnt != XFER_MAX) xferCnt <= xferCnt + 1'b1;
  end

  // end-data flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         edSeen <= 1'b0;
    else if (ctl.startCyc)             edSeen <= 1'b0;
    else if (ctl.sampleEd && edIn)     edSeen <= 1'b1;
  end

  assign finalXfer = edSeen || ((cfgXferLimit != '0) && (xferCnt >= cfgXferLimit));

  // captured controller address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              devAddr <= '0;
    else if (ctl.latchAddr) devAddr <= frIn;
  end

  // byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              byteCount <= '0;
    else if (ctl.startCyc)  byteCount <= '0;
    else if (ctl.countXfer) byteCount <= byteCount + byteStep;
  end

endmodule

// File: rtl/svc_seq_ctrl.sv
module svc_seq_ctrl
  import svc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   svcCallIn,
  input  logic   intCallIn,
  input  logic   aioReqIn,
  input  logic   fslIn,
  input  logic   rsIn,
  input  logic   timerDone,
  input  logic   dlyZero,
  input  logic   finalXfer,
  output dpCtl_t ctl,
  output logic   fsOut,
  output logic   ascOut,
  output logic   aioOut,
  output logic   rsaOut,
  output logic   esOut,
  output logic   noRespErrOut
);

  seqState_t state, stateNxt;
  logic      kindAio, kindAioNxt;
  logic      errNxt;

  always_comb begin
    stateNxt   = state;
    kindAioNxt = kindAio;
    errNxt     = 1'b0;
    ctl        = '0;
    case (state)
      ST_IDLE: begin
        if (svcCallIn) begin
          stateNxt     = ST_STROBE;
          kindAioNxt   = 1'b0;
          ctl.startCyc = 1'b1;
        end else if (aioReqIn && intCallIn) begin
          stateNxt     = ST_STROBE;
          kindAioNxt   = 1'b1;
          ctl.startCyc = 1'b1;
        end
      end
      ST_STROBE: begin
        if (fslIn) begin
          ctl.latchAddr = 1'b1;
          stateNxt      = ST_WDROP;
        end else if (timerDone) begin
          errNxt   = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          ctl.tmrInc = 1'b1;
        end
      end
      ST_WDROP: begin
        if (!fslIn) stateNxt = kindAio ? ST_IDLE : ST_RSWAIT;
      end
      ST_RSWAIT: begin
        ctl.sampleEd = 1'b1;
        if (rsIn) begin
          ctl.loadDly = 1'b1;
          stateNxt    = ST_RSDLY;
        end
      end
      ST_RSDLY: begin
        ctl.sampleEd = 1'b1;
        if (dlyZero) begin
          ctl.countXfer = 1'b1;
          stateNxt      = ST_RSACK;
        end else begin
          ctl.decDly = 1'b1;
        end
      end
      ST_RSACK: begin
        if (!rsIn) stateNxt = finalXfer ? ST_IDLE : ST_RSWAIT;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      kindAio      <= 1'b0;
      noRespErrOut <= 1'b0;
    end else begin
      state        <= stateNxt;
      kindAio      <= kindAioNxt;
      noRespErrOut <= errNxt;
    end
  end

  assign fsOut  = (state == ST_STROBE);
  assign ascOut = fsOut && !kindAio;
  assign aioOut = fsOut && kindAio;
  assign rsaOut = (state == ST_RSACK) && rsIn;
  assign esOut  = rsaOut && finalXfer;

endmodule

// File: rtl/svc_seq_top.sv
module svc_seq_top
  import svc_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DLY_W       = 4,
  parameter int XFER_W      = 8,
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              svcCallIn,
  input  logic              intCallIn,
  input  logic              aioReqIn,
  input  logic              fslIn,
  input  logic [ADDR_W-1:0] frIn,
  input  logic              rsIn,
  input  logic              edIn,
  input  logic [DLY_W-1:0]  cfgRsaDelay,
  input  logic [XFER_W-1:0] cfgXferLimit,
  input  logic [1:0]        cfgWidth,
  output logic              fsOut,
  output logic              ascOut,
  output logic              aioOut,
  output logic              rsaOut,
  output logic              esOut,
  output logic [ADDR_W-1:0] devAddrOut,
  output logic [CNT_W-1:0]  byteCountOut,
  output logic              noRespErrOut
);

  dpCtl_t ctl;
  logic   timerDone, dlyZero, finalXfer;

  svc_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .svcCallIn(svcCallIn), .intCallIn(intCallIn), .aioReqIn(aioReqIn),
    .fslIn(fslIn), .rsIn(rsIn),
    .timerDone(timerDone), .dlyZero(dlyZero), .finalXfer(finalXfer),
    .ctl(ctl),
    .fsOut(fsOut), .ascOut(ascOut), .aioOut(aioOut),
    .rsaOut(rsaOut), .esOut(esOut), .noRespErrOut(noRespErrOut)
  );

  svc_seq_dp #(
    .ADDR_W(ADDR_W), .DLY_W(DLY_W), .XFER_W(XFER_W),
    .CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .frIn(frIn), .edIn(edIn),
    .cfgRsaDelay(cfgRsaDelay), .cfgXferLimit(cfgXferLimit), .cfgWidth(cfgWidth),
    .timerDone(timerDone), .dlyZero(dlyZero), .finalXfer(finalXfer),
    .devAddr(devAddrOut), .byteCount(byteCountOut)
  );

endmodule

// File: rtl/svc_seq_chk.sv
module svc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic svcCallIn,
  input logic intCallIn,
  input logic aioReqIn,
  input logic fslIn,
  input logic rsIn,
  input logic fsOut,
  input logic ascOut,
  input logic aioOut,
  input logic rsaOut,
  input logic esOut,
  input logic noRespErrOut
);

  // R1
  asc_from_call_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ascOut) |-> $past(svcCallIn));

  // R2
  one_indicator_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ascOut, aioOut}));

  // R2
  indicator_needs_fs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ascOut || aioOut) |-> fsOut);

  // R3
  fs_drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsOut && fslIn) |=> !fsOut);

  // R4
  aio_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aioOut) |-> $past(aioReqIn && intCallIn && !svcCallIn));

  // R5
  rsa_delayed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rsaOut) |-> $past(rsIn));

  // R6
  rsa_follows_rs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rsIn |-> !rsaOut);

  // R7
  es_with_rsa_chk: assert property (@(posedge clk) disable iff (!rstN)
    esOut |-> rsaOut);

  // R10
  err_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    noRespErrOut |-> (!fsOut && $past(fsOut)));

endmodule

bind svc_seq_top svc_seq_chk chk_i (
  .clk(clk), .rstN(rstN),
  .svcCallIn(svcCallIn), .intCallIn(intCallIn), .aioReqIn(aioReqIn),
  .fslIn(fslIn), .rsIn(rsIn),
  .fsOut(fsOut), .ascOut(ascOut), .aioOut(aioOut),
  .rsaOut(rsaOut), .esOut(esOut), .noRespErrOut(noRespErrOut)
);

// File: tb/svc_seq_top_tb_top.sv
module svc_seq_top_tb_top;

  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        svcCallIn = 0, intCallIn = 0, aioReqIn = 0, fslIn = 0, rsIn = 0, edIn = 0;
  logic [7:0]  frIn = 0;
  logic [3:0]  cfgRsaDelay = 0;
  logic [7:0]  cfgXferLimit = 0;
  logic [1:0]  cfgWidth = 0;
  logic        fsOut, ascOut, aioOut, rsaOut, esOut, noRespErrOut;
  logic [7:0]  devAddrOut;
  logic [15:0] byteCountOut;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  svc_seq_top #(.TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rstN(rstN), .svcCallIn(svcCallIn), .intCallIn(intCallIn),
    .aioReqIn(aioReqIn), .fslIn(fslIn), .frIn(frIn), .rsIn(rsIn), .edIn(edIn),
    .cfgRsaDelay(cfgRsaDelay), .cfgXferLimit(cfgXferLimit), .cfgWidth(cfgWidth),
    .fsOut(fsOut), .ascOut(ascOut), .aioOut(aioOut), .rsaOut(rsaOut), .esOut(esOut),
    .devAddrOut(devAddrOut), .byteCountOut(byteCountOut), .noRespErrOut(noRespErrOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 strobing, 2 awaiting ack release, 3 awaiting request, 4 delaying, 5 acknowledging
  int phase = 0, waitLeft = 0, strobeAge = 0, xfers = 0, bytes = 0, addr = 0;
  bit aioCycle = 0, endData = 0, errPulse = 0;
  int rsaRises = 0, esCount = 0, errCount = 0;
  bit rsaPrev = 0;

  function automatic bit mFinal();
    return endData || (cfgXferLimit != 0 && xfers >= cfgXferLimit);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; strobeAge = 0; xfers = 0; bytes = 0; addr = 0;
      aioCycle = 0; endData = 0; errPulse = 0; waitLeft = 0;
    end else begin
      errPulse = 0;
      if (phase == 0) begin
        if (svcCallIn || (aioReqIn && intCallIn)) begin
          phase = 1; aioCycle = !svcCallIn; strobeAge = 0;
          xfers = 0; bytes = 0; endData = 0;
        end
      end else if (phase == 1) begin
        if (fslIn) begin addr = frIn; phase = 2; end
        else if (strobeAge == TO - 1) begin errPulse = 1; phase = 0; end
        else strobeAge++;
      end else if (phase == 2) begin
        if (!fslIn) phase = aioCycle ? 0 : 3;
      end else if (phase == 3) begin
        if (edIn) endData = 1;
        if (rsIn) begin waitLeft = cfgRsaDelay; phase = 4; end
      end else if (phase == 4) begin
        if (edIn) endData = 1;
        if (waitLeft == 0) begin
          phase = 5; xfers++;
          bytes = (bytes + ((cfgWidth == 0) ? 1 : (cfgWidth == 1) ? 2 : 4)) % 65536;
        end else waitLeft--;
      end else begin
        if (!rsIn) phase = mFinal() ? 0 : 3;
      end
    end
  end

  // compare every cycle, away from the edges
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      bit eFs, eRsa, eEs;
      eFs  = (phase == 1);
      eRsa = (phase == 5) && rsIn;
      eEs  = eRsa && mFinal();
      chk(fsOut == eFs, "R1 fsOut", fsOut, eFs);
      chk(ascOut == (eFs && !aioCycle), "R1 ascOut", ascOut, eFs && !aioCycle);
      chk(aioOut == (eFs && aioCycle), "R4 aioOut", aioOut, eFs && aioCycle);
      chk(rsaOut == eRsa, "R5 rsaOut", rsaOut, eRsa);
      chk(esOut == eEs, "R7 esOut", esOut, eEs);
      chk(devAddrOut == addr, "R3 devAddrOut", devAddrOut, addr);
      chk(byteCountOut == bytes, "R9 byteCountOut", byteCountOut, bytes);
      chk(noRespErrOut == errPulse, "R10 noRespErrOut", noRespErrOut, errPulse);
      if (rsaOut && !rsaPrev) rsaRises++;
      if (esOut) esCount++;
      if (noRespErrOut) errCount++;
      rsaPrev = rsaOut;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic devAnswer(input logic [7:0] a, input int lat);
    waitCyc(lat);
    fslIn = 1; frIn = a; svcCallIn = 0; aioReqIn = 0;
    @(negedge clk);
    while (fsOut) @(negedge clk);
    waitCyc(2);
    fslIn = 0;
    waitCyc(1);
  endtask

  task automatic xfer();
    @(negedge clk);
    rsIn = 1;
    forever begin
      @(negedge clk); #1;
      if (rsaOut) break;
    end
    waitCyc(1); #1;
    rsIn = 0;
    waitCyc(2);
  endtask

  initial begin
    waitCyc(3);
    // R11 reset state
    chk(!fsOut && !ascOut && !aioOut && !rsaOut && !esOut && !noRespErrOut,
        "R11 outputs in reset", {fsOut, ascOut, aioOut, rsaOut, esOut}, 0);
    chk(devAddrOut == 0 && byteCountOut == 0, "R11 regs in reset", devAddrOut, 0);
    rstN = 1;
    waitCyc(2);
    chk(!fsOut && byteCountOut == 0, "R11 after release", fsOut, 0);

    // service connection: 1-byte path, delay 2, limit 3
    cfgWidth = 0; cfgRsaDelay = 2; cfgXferLimit = 3;
    rsaRises = 0; esCount = 0;
    svcCallIn = 1;
    devAnswer(8'h5A, 3);
    repeat (3) xfer();
    waitCyc(3);
    chk(devAddrOut == 8'h5A, "R3 address latched", devAddrOut, 8'h5A);
    chk(rsaRises == 3, "R5 acknowledges per connection", rsaRises, 3);
    chk(esCount > 0, "R7 end-service on last transfer", esCount, 1);
    chk(byteCountOut == 3, "R9 one-byte count", byteCountOut, 3);

    // interrupt request without interrupt call is ignored
    aioReqIn = 1; intCallIn = 0;
    waitCyc(4);
    chk(!fsOut && !aioOut, "R4 request without call ignored", fsOut, 0);
    aioReqIn = 0;

    // interrupt acknowledge cycle
    intCallIn = 1; aioReqIn = 1;
    devAnswer(8'h33, 2);
    intCallIn = 0;
    waitCyc(4);
    chk(devAddrOut == 8'h33, "R4 interrupt address latched", devAddrOut, 8'h33);
    chk(!rsaOut && !fsOut, "R4 interrupt cycle ends idle", fsOut, 0);

    // priority: both at once, service wins; 2-byte path, delay 0, limit 2
    cfgWidth = 1; cfgRsaDelay = 0; cfgXferLimit = 2;
    intCallIn = 1; aioReqIn = 1; svcCallIn = 1;
    @(negedge clk); #3;
    chk(ascOut && !aioOut, "R4 service call wins", ascOut, 1);
    aioReqIn = 0; intCallIn = 0;
    devAnswer(8'hC1, 1);
    repeat (2) xfer();
    waitCyc(2);
    chk(byteCountOut == 4, "R9 two-byte count", byteCountOut, 4);

    // timeout
    errCount = 0;
    svcCallIn = 1;
    waitCyc(1);
    svcCallIn = 0;
    waitCyc(TO + 4);
    chk(errCount == 1, "R10 single error pulse", errCount, 1);
    chk(!fsOut, "R10 strobe abandoned", fsOut, 0);

    // end-data closes an unlimited connection; 4-byte path
    cfgWidth = 2; cfgRsaDelay = 1; cfgXferLimit = 0;
    esCount = 0;
    svcCallIn = 1;
    devAnswer(8'h07, 2);
    xfer();
    chk(esCount == 0, "R8 no end without end-data", esCount, 0);
    edIn = 1; waitCyc(1); edIn = 0;
    xfer();
    waitCyc(3);
    chk(esCount > 0, "R8 end-data gives end-service", esCount, 1);
    chk(byteCountOut == 8, "R9 four-byte count", byteCountOut, 8);
    rsIn = 1; waitCyc(4);
    chk(!rsaOut, "R7 idle after final acknowledge", rsaOut, 0);
    rsIn = 0; waitCyc(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule